// File: doc/BRIEF.md
# Disk Emulation Status Poll Endpoint

This block is the SPI slave that an external controller uses to watch and steer a floppy and hard-disk emulation engine. The controller selects it through a dedicated chip select and clocks out a 16-bit command word. While that word shifts in, the block answers with a status frame of fixed byte positions. The frame holds the drive selection, the current track, the disk sync word and some progress counters. The later bytes of the frame change meaning with the engine's state: they differ for a floppy track read, for a floppy track write and for a hard-disk read command.

Once the command word is complete, the block decodes it into one-cycle strobes for the disk engine. A floppy status command also carries two 4-bit masks, one for write-enabled drives and one for inserted media, and the block holds these masks until the next such command. The block also keeps the disk sync register. The engine loads that register, and it reads 16'h4489 out of reset. All SPI pins are sampled in the system clock domain through two-flop synchronizers. The SPI clock must therefore stay well below the system clock.

Top module: `disk_poll_spi`

## Requirements
- R1: SPI mode 0, MSB first. The first bit of byte 0 is on `spi_miso` before the first rising SCK edge. `spi_miso_en` is high exactly while chip select is asserted (low). Deasserting chip select restarts the frame at byte 0.
- R2: Byte 0, from bit 7 down to bit 0, is: `drv_sel[1:0]`, `drv_num[1:0]`, `hdd_dat_req`, `hdd_cmd_req`, `trk_wr`, and (`trk_rd` AND NOT `fifo_cnt[10]`).
- R3: Byte 1 is `track_no`. Bytes 2 and 3 are the sync register, high byte first. The sync register reads 16'h4489 after reset and takes `sync_din` on a cycle with `sync_load` high.
- R4: While `trk_rd` is high, bytes 4/5 are {`dma_en`, `dsk_len[14:0]`}. This holds even if `trk_wr` is also high.
- R5: While `trk_wr` is high and `trk_rd` is low, bytes 4/5 are {`dma_en` AND `dsk_len[14]`, 3'b000, `fifo_cnt[11:0]`}. With neither flag high they are zero.
- R6: Bytes 6/7 depend on the command of the current frame. For a floppy command (bits 15:13 = 000) they are {`dma_en`, `dsk_len`} during a track read, `fifo_out` during a track write and zero otherwise. For command codes 1000 and 1010 in bits 15:12 they are `hdd_din`. For all other codes they are zero.
- R7: Bytes after byte 7 of a frame read as zero.
- R8: The command is the first 16 bits received after select. It appears on `cmd_word` and raises one single-cycle strobe per frame, chosen by bits 15:12: 000x `stb_fdd`, 1000 `stb_hdd_rd`, 1001 `stb_hdd_wr`, 1010 `stb_data_rd`, 1011 `stb_data_wr`, 1111 `stb_hdd_stat`. Code 0001 raises `stb_fdd_stat` together with `stb_fdd`.
- R9: Codes 01xx, 1100, 1101 and 1110 raise no strobe. A frame cut short before 16 bits raises no strobe and leaves `cmd_word` unchanged.
- R10: On code 0001, `wr_mask` takes bits 7:4 and `present_mask` takes bits 3:0. Both masks reset to zero, and no other command changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from controller |
| spi_miso | output | 1 | Serial data to controller |
| spi_miso_en | output | 1 | Drive enable for `spi_miso` |
| drv_sel | input | 2 | Selected floppy index |
| drv_num | input | 2 | Installed floppy count |
| hdd_dat_req | input | 1 | Hard-disk data request pending |
| hdd_cmd_req | input | 1 | Hard-disk command request pending |
| trk_wr | input | 1 | Floppy track write active |
| trk_rd | input | 1 | Floppy track read active |
| fifo_cnt | input | 12 | Disk FIFO fill count |
| track_no | input | 8 | Current floppy track |
| sync_load | input | 1 | Load the sync register |
| sync_din | input | 16 | New sync register value |
| dma_en | input | 1 | Disk DMA running |
| dsk_len | input | 15 | Disk length without trigger bit |
| fifo_out | input | 16 | FIFO output word |
| hdd_din | input | 16 | Hard-disk data word |
| cmd_word | output | 16 | Last complete command word |
| wr_mask | output | 4 | Write-enabled drive mask |
| present_mask | output | 4 | Inserted media mask |
| stb_fdd | output | 1 | Floppy command strobe |
| stb_fdd_stat | output | 1 | Floppy status command strobe |
| stb_hdd_rd | output | 1 | Hard-disk read strobe |
| stb_hdd_wr | output | 1 | Hard-disk write strobe |
| stb_data_rd | output | 1 | Data read strobe |
| stb_data_wr | output | 1 | Data write strobe |
| stb_hdd_stat | output | 1 | Hard-disk status write strobe |

## Verification
The bench uses the default parameter, so the sync register starts at 16'h4489. This reset value is checked before any load, and a load is checked afterwards. The SPI half period is eight system clocks. That is long enough for the synchronizers and edge detectors to settle, so every returned bit can be compared with a model. Frames run past byte 7 to reach the zero tail. They are also cut short after one byte, which exercises the restart and the incomplete-command rule.

// File: rtl/disk_poll_spi.sv
module disk_poll_spi #(
  parameter logic [15:0] SYNC_INIT = 16'h4489
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic        spi_miso_en,
  input  logic [1:0]  drv_sel,
  input  logic [1:0]  drv_num,
  input  logic        hdd_dat_req,
  input  logic        hdd_cmd_req,
  input  logic        trk_wr,
  input  logic        trk_rd,
  input  logic [11:0] fifo_cnt,
  input  logic [7:0]  track_no,
  input  logic        sync_load,
  input  logic [15:0] sync_din,
  input  logic        dma_en,
  input  logic [14:0] dsk_len,
  input  logic [15:0] fifo_out,
  input  logic [15:0] hdd_din,
  output logic [15:0] cmd_word,
  output logic [3:0]  wr_mask,
  output logic [3:0]  present_mask,
  output logic        stb_fdd,
  output logic        stb_fdd_stat,
  output logic        stb_hdd_rd,
  output logic        stb_hdd_wr,
  output logic        stb_data_rd,
  output logic        stb_data_wr,
  output logic        stb_hdd_stat
);

  localparam int NBYTES = 8;
  localparam int IW     = $clog2(NBYTES) + 1;

  logic [2:0]    sck_q, cs_q;
  logic [1:0]    mosi_q;
  logic          sel, sck_rise, sck_fall;
  logic [2:0]    bit_idx;
  logic [IW-1:0] byte_idx;
  logic [7:0]    tx_sh, nxt_byte;
  logic [14:0]   rx_sh;
  logic          cmd_done;
  logic [15:0]   sync_q, w45, w67;
  logic [7:0]    frame [NBYTES];
  logic          is_fdd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], spi_sck};
      cs_q   <= {cs_q[1:0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  assign sel      = ~cs_q[1];
  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];

  assign is_fdd = (cmd_word[15:13] == 3'b000);

  assign w45 = trk_rd ? {dma_en, dsk_len} :
               trk_wr ? {dma_en & dsk_len[14], 3'b000, fifo_cnt} : 16'h0000;

  always_comb begin
    w67 = '0;
    if (is_fdd) begin
      if (trk_rd)      w67 = {dma_en, dsk_len};
      else if (trk_wr) w67 = fifo_out;
    end else if (cmd_word[15:12] == 4'b1000 || cmd_word[15:12] == 4'b1010) begin
      w67 = hdd_din;
    end
  end

  assign frame[0] = {drv_sel, drv_num, hdd_dat_req, hdd_cmd_req, trk_wr, trk_rd & ~fifo_cnt[10]};
  assign frame[1] = track_no;
  assign frame[2] = sync_q[15:8];
  assign frame[3] = sync_q[7:0];
  assign frame[4] = w45[15:8];
  assign frame[5] = w45[7:0];
  assign frame[6] = w67[15:8];
  assign frame[7] = w67[7:0];

  assign nxt_byte = byte_idx[IW-1] ? 8'h00 : frame[byte_idx[IW-2:0]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_idx  <= '0;
      byte_idx <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      cmd_word <= '0;
      cmd_done <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      if (!sel) begin
        bit_idx  <= '0;
        byte_idx <= '0;
        tx_sh    <= nxt_byte;
      end else begin
        if (sck_rise) begin
          rx_sh   <= {rx_sh[13:0], mosi_q[1]};
          bit_idx <= bit_idx + 3'd1;
          if (bit_idx == 3'd7) begin
            if (!byte_idx[IW-1]) byte_idx <= byte_idx + 1'b1;
            if (byte_idx == IW'(1)) begin
              cmd_word <= {rx_sh, mosi_q[1]};
              cmd_done <= 1'b1;
            end
          end
        end
        if (sck_fall)
          tx_sh <= (bit_idx == 3'd0) ? nxt_byte : {tx_sh[6:0], 1'b0};
      end
    end

  assign spi_miso    = sel & tx_sh[7];
  assign spi_miso_en = sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stb_fdd      <= 1'b0;
      stb_fdd_stat <= 1'b0;
      stb_hdd_rd   <= 1'b0;
      stb_hdd_wr   <= 1'b0;
      stb_data_rd  <= 1'b0;
      stb_data_wr  <= 1'b0;
      stb_hdd_stat <= 1'b0;
      wr_mask      <= '0;
      present_mask <= '0;
    end else begin
      stb_fdd      <= cmd_done & is_fdd;
      stb_fdd_stat <= cmd_done & (cmd_word[15:12] == 4'b0001);
      stb_hdd_rd   <= cmd_done & (cmd_word[15:12] == 4'b1000);
      stb_hdd_wr   <= cmd_done & (cmd_word[15:12] == 4'b1001);
      stb_data_rd  <= cmd_done & (cmd_word[15:12] == 4'b1010);
      stb_data_wr  <= cmd_done & (cmd_word[15:12] == 4'b1011);
      stb_hdd_stat <= cmd_done & (cmd_word[15:12] == 4'b1111);
      if (cmd_done && cmd_word[15:12] == 4'b0001) begin
        wr_mask      <= cmd_word[7:4];
        present_mask <= cmd_word[3:0];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         sync_q <= SYNC_INIT;
    else if (sync_load) sync_q <= sync_din;

  a_r9_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb_fdd, stb_hdd_rd, stb_hdd_wr, stb_data_rd, stb_data_wr, stb_hdd_stat}));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fdd | stb_hdd_rd | stb_hdd_wr | stb_data_rd | stb_data_wr | stb_hdd_stat) |=>
    !(stb_fdd | stb_hdd_rd | stb_hdd_wr | stb_data_rd | stb_data_wr | stb_hdd_stat));

  a_r8_stat_with_fdd: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fdd_stat |-> stb_fdd);

  a_r10_masks_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_done |=> $stable({wr_mask, present_mask}));

  a_r3_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_load |=> $stable(sync_q));

  a_r7_index_limit: assert property (@(posedge clk) disable iff (!rst_n)
    byte_idx <= IW'(NBYTES));

endmodule

// File: tb/test_disk_poll_spi.sv
`timescale 1ns/1ps
module test_disk_poll_spi;
  localparam int HALF = 64;

  logic clk = 0, rst_n = 0;
  logic spi_sck = 0, spi_cs_n = 1, spi_mosi = 0;
  logic spi_miso, spi_miso_en;
  logic [1:0] drv_sel = 0, drv_num = 0;
  logic hdd_dat_req = 0, hdd_cmd_req = 0, trk_wr = 0, trk_rd = 0;
  logic [11:0] fifo_cnt = 0;
  logic [7:0] track_no = 0;
  logic sync_load = 0;
  logic [15:0] sync_din = 0;
  logic dma_en = 0;
  logic [14:0] dsk_len = 0;
  logic [15:0] fifo_out = 0, hdd_din = 0;
  logic [15:0] cmd_word;
  logic [3:0] wr_mask, present_mask;
  logic stb_fdd, stb_fdd_stat, stb_hdd_rd, stb_hdd_wr, stb_data_rd, stb_data_wr, stb_hdd_stat;

  int total = 0, bad = 0;
  int n_stb [7];
  logic [7:0] rx [12];
  logic [15:0] m_sync = 16'h4489;
  logic [3:0] m_wr = 0, m_pr = 0;

  always #4 clk = ~clk;

  disk_poll_spi i_disk_poll_spi (.*);

  always @(posedge clk) begin
    if (stb_fdd)      n_stb[0]++;
    if (stb_fdd_stat) n_stb[1]++;
    if (stb_hdd_rd)   n_stb[2]++;
    if (stb_hdd_wr)   n_stb[3]++;
    if (stb_data_rd)  n_stb[4]++;
    if (stb_data_wr)  n_stb[5]++;
    if (stb_hdd_stat) n_stb[6]++;
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_w67(logic [15:0] c);
    if (c[15:13] == 3'b000) begin
      if (trk_rd) return {dma_en, dsk_len};
      if (trk_wr) return fifo_out;
      return 16'h0;
    end
    if (c[15:12] == 4'b1000 || c[15:12] == 4'b1010) return hdd_din;
    return 16'h0;
  endfunction

  function automatic logic [7:0] exp_byte(int i, logic [15:0] c);
    logic [15:0] w45;
    w45 = trk_rd ? {dma_en, dsk_len} : trk_wr ? {dma_en & dsk_len[14], 3'b000, fifo_cnt} : 16'h0;
    case (i)
      0: return {drv_sel, drv_num, hdd_dat_req, hdd_cmd_req, trk_wr, trk_rd & ~fifo_cnt[10]};
      1: return track_no;
      2: return m_sync[15:8];
      3: return m_sync[7:0];
      4: return w45[15:8];
      5: return w45[7:0];
      6: return exp_w67(c) >> 8;
      7: return exp_w67(c) & 16'hff;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(int i);
    if (i == 0) return "R2";
    if (i < 4) return "R3";
    if (i < 6) return trk_rd ? "R4" : "R5";
    if (i < 8) return "R6";
    return "R7";
  endfunction

  task automatic xfer(logic [15:0] c, int n);
    @(negedge clk);
    foreach (n_stb[j]) n_stb[j] = 0;
    spi_cs_n = 0;
    for (int i = 0; i < n; i++) begin
      for (int k = 7; k >= 0; k--) begin
        spi_mosi = (i < 2) ? c[(1 - i) * 8 + k] : 1'b0;
        #HALF;
        rx[i][k] = spi_miso;
        spi_sck = 1;
        #HALF;
        spi_sck = 0;
      end
    end
    #HALF;
    spi_cs_n = 1;
    spi_mosi = 0;
    #(HALF * 2);
  endtask

  task automatic frame(logic [15:0] c, int n);
    xfer(c, n);
    for (int i = 0; i < n; i++)
      chk($sformatf("%s byte%0d cmd=%h", tag_of(i), i, c), rx[i], exp_byte(i, c));
  endtask

  task automatic chk_stb(string tag, logic [6:0] e);
    for (int j = 0; j < 7; j++)
      chk($sformatf("%s strobe%0d count", tag, j), 16'(n_stb[j]), {15'd0, e[j]});
  endtask

  task automatic chk_masks(string tag);
    chk({tag, " wr_mask"}, wr_mask, m_wr);
    chk({tag, " present_mask"}, present_mask, m_pr);
  endtask

  task automatic t_reset;
    chk("R1 enable idle", spi_miso_en, 0);
    chk("R1 miso idle", spi_miso, 0);
    chk_masks("R10 reset");
    chk("R8 cmd reset", cmd_word, 0);
  endtask

  task automatic t_plain;
    drv_sel = 2'd2; drv_num = 2'd3; hdd_dat_req = 1; track_no = 8'h4f;
    fifo_out = 16'h1357; hdd_din = 16'h2468;
    frame(16'h0000, 10);
    chk_stb("R8 fdd", 7'b0000001);
    chk("R8 cmd_word", cmd_word, 16'h0000);
    hdd_dat_req = 0; hdd_cmd_req = 1; drv_sel = 2'd1; drv_num = 2'd0; track_no = 8'ha0;
    frame(16'h0FFF, 12);
  endtask

  task automatic t_track_read;
    trk_rd = 1; fifo_cnt = 12'h3ff; dma_en = 1; dsk_len = 15'h2abc;
    frame(16'h0000, 8);
    fifo_cnt = 12'h400; dma_en = 0; dsk_len = 15'h7001;
    frame(16'h0123, 8);
    trk_rd = 0;
  endtask

  task automatic t_track_write;
    trk_wr = 1; dma_en = 1; dsk_len = 15'h4123; fifo_cnt = 12'habc; fifo_out = 16'hbeef;
    frame(16'h0100, 8);
    dsk_len = 15'h0123;
    frame(16'h0100, 8);
    trk_rd = 1;
    frame(16'h0000, 8);
    trk_rd = 0; trk_wr = 0;
  endtask

  task automatic t_hdd;
    trk_rd = 1; dma_en = 1; dsk_len = 15'h1111; hdd_din = 16'hcafe;
    frame(16'h8000, 8); chk_stb("R8 hdd_rd", 7'b0000100);
    frame(16'hA055, 8); chk_stb("R8 data_rd", 7'b0010000);
    chk("R8 cmd_word data_rd", cmd_word, 16'hA055);
    frame(16'h9000, 8); chk_stb("R8 hdd_wr", 7'b0001000);
    trk_rd = 0;
    frame(16'hB0F0, 8); chk_stb("R8 data_wr", 7'b0100000);
    frame(16'hF000, 8); chk_stb("R8 hdd_stat", 7'b1000000);
  endtask

  task automatic t_status;
    frame(16'h10A5, 8);
    m_wr = 4'hA; m_pr = 4'h5;
    chk_stb("R8 fdd_stat", 7'b0000011);
    chk_masks("R10 latch");
    frame(16'h90C3, 8);
    chk_masks("R10 hold on hdd_wr");
    frame(16'h013C, 8);
    chk_masks("R10 hold on fdd");
  endtask

  task automatic t_ignored;
    logic [15:0] codes [4] = '{16'hC000, 16'hD0FF, 16'h4000, 16'hE012};
    hdd_din = 16'h5a5a;
    foreach (codes[j]) begin
      frame(codes[j], 8);
      chk_stb("R9 ignored", 7'b0000000);
      chk_masks("R9 masks");
    end
  endtask

  task automatic t_sync;
    @(negedge clk);
    sync_din = 16'h1234; sync_load = 1;
    @(negedge clk);
    sync_load = 0; sync_din = 16'hffff;
    m_sync = 16'h1234;
    frame(16'h0000, 4);
  endtask

  task automatic t_restart;
    @(negedge clk);
    spi_cs_n = 0;
    #HALF;
    chk("R1 enable selected", spi_miso_en, 1);
    spi_cs_n = 1;
    #(HALF * 2);
    chk("R1 enable deselected", spi_miso_en, 0);
    xfer(16'hB000, 1);
    chk_stb("R9 short frame", 7'b0000000);
    chk("R9 cmd unchanged", cmd_word, 16'h0000);
    drv_sel = 2'd3; trk_wr = 1; fifo_cnt = 12'h055;
    frame(16'h0000, 6);
    trk_wr = 0;
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_plain;
    t_track_read;
    t_track_write;
    t_hdd;
    t_ignored;
    t_status;
    t_sync;
    chk("R8 cmd before restart", cmd_word, 16'h0000);
    t_restart;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule